// File: doc/BRIEF.md
# Cache Array Direct Access Port

This block lets a processor bus reach the two storage arrays of a four-way set-associative write-back cache directly. The arrays are the tag store, which holds a tag, a valid flag and a dirty flag per line, and the line data store. Two 16 MiB windows are set aside in the address space for this. The block decodes each bus access into four parts: which array is addressed, the entry index, the way, and either the longword within the line or the associative flag. It then reads or updates that storage.

Tag writes have two forms. A plain write overwrites the tag, dirty and valid flags of the addressed way. An associative write compares its tag with every way of the indexed entry and changes only the flags of the way that matches; if no way matches, nothing changes. Either form may clear the valid flag of a line that is valid and dirty. When that happens, the block holds the access and raises a write-back request to an external engine. It completes the invalidation only after the engine acknowledges.

Top module: `cache_array_port`

## Requirements
- R1: An access whose address has upper byte 0xF0 goes to the tag store, and upper byte 0xF1 goes to the data store. Any other upper byte is never acknowledged, and it leaves both stores untouched.
- R2: Address bits 11:4 give the entry, bits 13:12 give the way, and bits 3:2 give the longword within a data line.
- R3: With address bit 3 clear, a tag-store write stores write-data bits 31:10 as the tag, bit 1 as the dirty flag and bit 0 as the valid flag. A tag-store read returns the same layout, with bits 9:2 zero.
- R4: With address bit 3 set, a tag-store write updates the dirty and valid flags of the lowest valid way whose tag equals write-data bits 31:10. If no way matches, the write changes nothing.
- R5: A tag-store read with address bit 3 set returns the way selected by bits 13:12, exactly as a plain read does.
- R6: A write that clears the valid flag of a line that is valid and dirty raises the write-back request. While the request is high, ready stays low. After the acknowledge, the line reads back as invalid.
- R7: A data-store write replaces the addressed longword. A data-store read returns the longword last written there.
- R8: Without a write-back, ready pulses high for exactly one cycle, two clock edges after the request is first seen. The request must be held until then.
- R9: After reset every line is invalid and clean, and ready and the write-back request are low.
- R10: The write-back request stays high, with a stable entry and way, until the acknowledge arrives. It also reports the entry and way of the line being evicted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busReq | input | 1 | Access request, held until busReady |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 32 | Access address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busReady is high |
| busReady | output | 1 | One-cycle completion strobe |
| wbReq | output | 1 | Write-back request for a dirty line being invalidated |
| wbAck | input | 1 | Write-back done |
| wbEntry | output | 8 | Entry of the line to write back |
| wbWay | output | 2 | Way of the line to write back |

## Verification
Assertions check every cycle that ready is a single-cycle pulse and that ready stays low while a write-back is pending. They also check that the write-back request and its entry and way hold steady until acknowledged, that an associative miss leaves the flags unchanged, and that an acknowledged eviction actually clears a valid flag. The bench scenarios are needed for everything else. They show the stored tag and data values against a reference model, the choice of way on associative writes when tags repeat, the exact latency, that out-of-window accesses get no response, and that the flags read as cleared after reset.

// File: rtl/cache_port_pkg.sv
package cache_port_pkg;
  localparam int TAG_W = 22;

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_WB, ST_RESP} port_state_t;

  typedef struct packed {
    logic capture;
    logic commitTag;
    logic commitData;
    logic loadRead;
  } port_strobe_t;

  typedef struct packed {
    logic inTag;
    logic isWrite;
    logic needWb;
  } port_status_t;
endpackage

// File: rtl/cache_port_datapath.sv
module cache_port_datapath
  import cache_port_pkg::*;
#(
  parameter int ENTRY_BITS = 8,
  parameter int WAY_BITS = 2,
  parameter logic [7:0] TAG_SPACE = 8'hF0,
  parameter logic [7:0] DATA_SPACE = 8'hF1
) (
  input  logic clk,
  input  logic rstN,
  input  logic [31:0] busAddr,
  input  logic [31:0] busWdata,
  input  logic busWe,
  input  port_strobe_t strobe,
  output port_status_t status,
  output logic winHit,
  output logic [31:0] rdData,
  output logic [ENTRY_BITS-1:0] wbEntry,
  output logic [WAY_BITS-1:0] wbWay
);
  localparam int WAYS = 1 << WAY_BITS;
  localparam int ENTRIES = 1 << ENTRY_BITS;
  localparam int LINES = ENTRIES * WAYS;
  localparam int LINE_W = ENTRY_BITS + WAY_BITS;
  localparam int WORD_IDX_W = LINE_W + 2;
  localparam int WORD_COUNT = LINES * 4;
  localparam int ENTRY_LSB = 4;
  localparam int WAY_LSB = ENTRY_LSB + ENTRY_BITS;
  localparam int FIELD_TOP = WAY_LSB + WAY_BITS;

  logic [TAG_W-1:0] tagMem [LINES];
  logic [31:0] dataMem [WORD_COUNT];
  logic [LINES-1:0] validBits, dirtyBits;

  logic isTagR, weR, assocR;
  logic [ENTRY_BITS-1:0] entryR;
  logic [WAY_BITS-1:0] wayR, firstHit, targetWay;
  logic [1:0] wordR;
  logic [31:0] dR;
  logic [WAYS-1:0] hitVec;
  logic anyHit, targetOk, needWb;
  logic [LINE_W-1:0] tIdx, pIdx;
  logic [WORD_IDX_W-1:0] wIdx;
  logic unusedAddrBits;

  assign unusedAddrBits = ^{busAddr[23:FIELD_TOP], busAddr[1:0]};
  assign winHit = (busAddr[31:24] == TAG_SPACE) || (busAddr[31:24] == DATA_SPACE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isTagR <= 1'b0; weR <= 1'b0; assocR <= 1'b0;
      entryR <= '0; wayR <= '0; wordR <= '0; dR <= '0;
    end else if (strobe.capture) begin
      isTagR <= (busAddr[31:24] == TAG_SPACE);
      weR <= busWe;
      assocR <= busAddr[3];
      entryR <= busAddr[ENTRY_LSB +: ENTRY_BITS];
      wayR <= busAddr[WAY_LSB +: WAY_BITS];
      wordR <= busAddr[3:2];
      dR <= busWdata;
    end
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    localparam logic [WAY_BITS-1:0] GW = WAY_BITS'(g);
    assign hitVec[g] = validBits[{entryR, GW}] && (tagMem[{entryR, GW}] == dR[31:10]);
  end

  always_comb begin
    firstHit = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (hitVec[i]) firstHit = WAY_BITS'(i);
    end
  end

  assign anyHit = |hitVec;
  assign targetWay = assocR ? firstHit : wayR;
  assign targetOk = !assocR || anyHit;
  assign tIdx = {entryR, targetWay};
  assign pIdx = {entryR, wayR};
  assign wIdx = {entryR, wayR, wordR};
  assign needWb = isTagR && weR && targetOk && validBits[tIdx] && dirtyBits[tIdx] && !dR[0];

  always_ff @(posedge clk) begin
    if (strobe.commitTag && !assocR) tagMem[tIdx] <= dR[31:10];
    if (strobe.commitData) dataMem[wIdx] <= dR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validBits <= '0;
      dirtyBits <= '0;
    end else if (strobe.commitTag && targetOk) begin
      validBits[tIdx] <= dR[0];
      dirtyBits[tIdx] <= dR[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strobe.loadRead)
      rdData <= isTagR ? {tagMem[pIdx], 8'b0, dirtyBits[pIdx], validBits[pIdx]} : dataMem[wIdx];
  end

  assign status = '{inTag: isTagR, isWrite: weR, needWb: needWb};
  assign wbEntry = entryR;
  assign wbWay = targetWay;

  // R4: an associative write that misses every way leaves all flags alone
  assert_assoc_miss_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commitTag && assocR && !anyHit) |=> ($stable(validBits) && $stable(dirtyBits)));

  // R6: committing an eviction really drops a valid flag
  assert_wb_invalidates_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commitTag && needWb) |=> ($countones(validBits) < $countones($past(validBits))));
endmodule

// File: rtl/cache_port_control.sv
module cache_port_control
  import cache_port_pkg::*;
#(
  parameter int ENTRY_BITS = 8,
  parameter int WAY_BITS = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic busReq,
  input  logic winHit,
  input  port_status_t status,
  input  logic wbAck,
  input  logic [ENTRY_BITS-1:0] wbEntry,
  input  logic [WAY_BITS-1:0] wbWay,
  output port_strobe_t strobe,
  output logic busReady,
  output logic wbReq
);
  port_state_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe = '0;
    unique case (state)
      ST_IDLE: if (busReq && winHit) begin
        strobe.capture = 1'b1;
        nextState = ST_EXEC;
      end
      ST_EXEC: begin
        if (status.needWb) begin
          nextState = ST_WB;
        end else begin
          strobe.commitTag = status.isWrite && status.inTag;
          strobe.commitData = status.isWrite && !status.inTag;
          strobe.loadRead = !status.isWrite;
          nextState = ST_RESP;
        end
      end
      ST_WB: if (wbAck) begin
        strobe.commitTag = 1'b1;
        nextState = ST_RESP;
      end
      ST_RESP: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign busReady = (state == ST_RESP);
  assign wbReq = (state == ST_WB);

  // R8: completion is a single-cycle strobe
  assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    busReady |=> !busReady);

  // R6: no completion while an eviction is outstanding
  assert_quiet_during_wb_R6: assert property (@(posedge clk) disable iff (!rstN)
    wbReq |-> !busReady);

  // R10: request and its target hold until acknowledged
  assert_wb_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && !wbAck) |=> (wbReq && $stable(wbEntry) && $stable(wbWay)));
endmodule

// File: rtl/cache_array_port.sv
module cache_array_port
  import cache_port_pkg::*;
#(
  parameter int ENTRY_BITS = 8,
  parameter int WAY_BITS = 2,
  parameter logic [7:0] TAG_SPACE = 8'hF0,
  parameter logic [7:0] DATA_SPACE = 8'hF1
) (
  input  logic clk,
  input  logic rstN,
  input  logic busReq,
  input  logic busWe,
  input  logic [31:0] busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic busReady,
  output logic wbReq,
  input  logic wbAck,
  output logic [ENTRY_BITS-1:0] wbEntry,
  output logic [WAY_BITS-1:0] wbWay
);
  port_strobe_t strobe;
  port_status_t status;
  logic winHit;

  cache_port_datapath #(
    .ENTRY_BITS(ENTRY_BITS), .WAY_BITS(WAY_BITS),
    .TAG_SPACE(TAG_SPACE), .DATA_SPACE(DATA_SPACE)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
    .strobe(strobe), .status(status), .winHit(winHit), .rdData(busRdata),
    .wbEntry(wbEntry), .wbWay(wbWay)
  );

  cache_port_control #(.ENTRY_BITS(ENTRY_BITS), .WAY_BITS(WAY_BITS)) i_control (
    .clk(clk), .rstN(rstN), .busReq(busReq), .winHit(winHit), .status(status),
    .wbAck(wbAck), .wbEntry(wbEntry), .wbWay(wbWay), .strobe(strobe),
    .busReady(busReady), .wbReq(wbReq)
  );
endmodule

// File: tb/test_cache_array_port.sv
module test_cache_array_port;
  logic clk = 0, rstN = 0;
  logic busReq = 0, busWe = 0, wbAck = 0;
  logic [31:0] busAddr = 0, busWdata = 0, busRdata;
  logic busReady, wbReq;
  logic [7:0] wbEntry;
  logic [1:0] wbWay;

  int nChecks = 0, nFails = 0, cycles = 0;
  bit finished = 0;

  logic [21:0] refTag [16][4];
  bit refV [16][4];
  bit refU [16][4];
  logic [31:0] refData [16][4][4];
  logic [21:0] tagPool [4] = '{22'h000440, 22'h2AAAAA, 22'h155555, 22'h3F00F0};

  always #10 clk = ~clk;

  cache_array_port i_cache_array_port (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady), .wbReq(wbReq),
    .wbAck(wbAck), .wbEntry(wbEntry), .wbWay(wbWay)
  );

  function automatic logic [31:0] tagAddr(int e, int w, bit a);
    return {8'hF0, 10'b0, 2'(w), 8'(e), a, 3'b0};
  endfunction
  function automatic logic [31:0] dataAddr(int e, int w, int k);
    return {8'hF1, 10'b0, 2'(w), 8'(e), 2'(k), 2'b0};
  endfunction
  function automatic logic [31:0] expTagWord(int e, int w);
    return {refTag[e][w], 8'b0, refU[e][w], refV[e][w]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bench responder for the write-back engine: acknowledges on the 3rd cycle of a request
  initial begin
    int ackCnt = 0;
    forever begin
      @(negedge clk);
      if (wbAck) wbAck = 0;
      else if (wbReq) begin
        ackCnt++;
        if (ackCnt == 3) begin wbAck = 1; ackCnt = 0; end
      end else ackCnt = 0;
    end
  end

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int lat, output int wbCyc,
                        output int wbE, output int wbW, output bit readyInWb);
    @(negedge clk);
    busReq = 1; busWe = we; busAddr = a; busWdata = d;
    lat = 0; wbCyc = 0; wbE = -1; wbW = -1; readyInWb = 0;
    do begin
      @(negedge clk);
      lat++;
      if (wbReq) begin
        if (wbCyc > 0 && (wbE != int'(wbEntry) || wbW != int'(wbWay))) readyInWb = 1;
        wbCyc++; wbE = wbEntry; wbW = wbWay;
        if (busReady) readyInWb = 1;
      end
    end while (!busReady && lat < 40);
    rd = busRdata;
    busReq = 0;
  endtask

  // Model of a tag write; returns whether an eviction is expected and on which way
  task automatic modelTagWrite(int e, int w, bit a, logic [31:0] d, output bit wb, output int ww);
    int t = -1;
    wb = 0; ww = -1;
    if (!a) t = w;
    else for (int i = 3; i >= 0; i--) if (refV[e][i] && refTag[e][i] == d[31:10]) t = i;
    if (t < 0) return;
    if (refV[e][t] && refU[e][t] && !d[0]) begin wb = 1; ww = t; end
    if (!a) refTag[e][t] = d[31:10];
    refV[e][t] = d[0]; refU[e][t] = d[1];
  endtask

  task automatic tagWrite(string req, int e, int w, bit a, logic [31:0] d);
    logic [31:0] rd; int lat, wbCyc, wbE, wbW; bit bad, expWb; int expWay;
    modelTagWrite(e, w, a, d, expWb, expWay);
    access(1, tagAddr(e, w, a), d, rd, lat, wbCyc, wbE, wbW, bad);
    check({req, " wb raised"}, 32'(wbCyc > 0), 32'(expWb));
    if (expWb) begin
      check("R10 wb entry", 32'(wbE), 32'(e));
      check("R10 wb way", 32'(wbW), 32'(expWay));
      check("R10 wb held until ack", 32'(wbCyc), 32'd3);
      check("R6 no ready during wb", 32'(bad), 32'd0);
    end else check("R8 latency", 32'(lat), 32'd2);
  endtask

  task automatic tagRead(string req, int e, int w, bit a);
    logic [31:0] rd; int lat, wbCyc, wbE, wbW; bit bad;
    access(0, tagAddr(e, w, a), 0, rd, lat, wbCyc, wbE, wbW, bad);
    check(req, rd, expTagWord(e, w));
  endtask

  task automatic dataWrite(int e, int w, int k, logic [31:0] d);
    logic [31:0] rd; int lat, wbCyc, wbE, wbW; bit bad;
    refData[e][w][k] = d;
    access(1, dataAddr(e, w, k), d, rd, lat, wbCyc, wbE, wbW, bad);
    check("R8 data write latency", 32'(lat), 32'd2);
  endtask

  task automatic dataRead(string req, int e, int w, int k);
    logic [31:0] rd; int lat, wbCyc, wbE, wbW; bit bad;
    access(0, dataAddr(e, w, k), 0, rd, lat, wbCyc, wbE, wbW, bad);
    check(req, rd, refData[e][w][k]);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nChecks++; nFails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        summary();
      end
    end
  end

  initial begin
    logic [31:0] rd; int lat, wbCyc, wbE, wbW; bit bad;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9: outputs idle after reset
    check("R9 ready low", 32'(busReady), 0);
    check("R9 wbReq low", 32'(wbReq), 0);
    rstN = 1;
    // R9: flags clear after reset
    access(0, tagAddr(200, 3, 0), 0, rd, lat, wbCyc, wbE, wbW, bad);
    check("R9 flags clear", {30'b0, rd[1:0]}, 0);
    check("R8 read latency", 32'(lat), 2);

    // R3 and R7: fill entries 0..15 fully
    for (int e = 0; e < 16; e++)
      for (int w = 0; w < 4; w++) begin
        refV[e][w] = 0; refU[e][w] = 0;
        tagWrite("R3", e, w, 0, {tagPool[(e + w) % 4], 8'b0, 2'b01});
        for (int k = 0; k < 4; k++) dataWrite(e, w, k, $urandom);
      end
    tagRead("R3 plain read format", 5, 2, 0);
    // R5: associative read returns the indexed way
    tagRead("R5 assoc read", 5, 3, 1);
    // R2 and R7: longword 3 of way 0, entry 4
    dataWrite(4, 0, 3, 32'hCAFE0003);
    dataWrite(4, 0, 2, 32'h0BAD0002);
    dataRead("R2 longword select", 4, 0, 3);
    dataWrite(4, 1, 3, 32'h11112222);
    dataRead("R2 way select", 4, 0, 3);
    dataRead("R7 data read", 4, 1, 3);

    // R6: dirty line in entry 8 way 0, then associative invalidate
    tagWrite("R3", 8, 0, 0, {22'h000440, 8'b0, 2'b11});
    tagWrite("R6", 8, 0, 1, {22'h000440, 8'b0, 2'b00});
    tagRead("R6 line invalid after ack", 8, 0, 0);
    // R4: associative miss changes nothing
    tagWrite("R3", 9, 1, 0, {22'h123456, 8'b0, 2'b11});
    tagWrite("R4 miss", 9, 1, 1, {22'h0ABCDE, 8'b0, 2'b00});
    tagRead("R4 miss no change", 9, 1, 0);
    // R4: associative hit on way 2 only updates flags
    tagWrite("R3", 10, 2, 0, {22'h0F0F0F, 8'b0, 2'b01});
    tagWrite("R4 hit", 10, 2, 1, {22'h0F0F0F, 8'b0, 2'b11});
    tagRead("R4 hit updated", 10, 2, 0);
    // R6: plain write clearing a dirty line also evicts
    tagWrite("R6 plain", 10, 2, 0, {22'h000001, 8'b0, 2'b00});
    tagRead("R6 plain result", 10, 2, 0);

    // R1: out-of-window accesses never acknowledged and store untouched
    foreach (tagPool[i]) begin end
    for (int n = 0; n < 2; n++) begin
      bit seen = 0;
      @(negedge clk);
      busReq = 1; busWe = 1; busWdata = 32'h0;
      busAddr = (n == 0) ? 32'hF2000050 : 32'h00000050;
      repeat (6) begin @(negedge clk); if (busReady) seen = 1; end
      busReq = 0;
      check("R1 no ack outside window", 32'(seen), 0);
    end
    tagRead("R1 tag store untouched", 5, 0, 0);
    dataRead("R1 data store untouched", 5, 0, 0);

    // Random mix
    for (int n = 0; n < 500; n++) begin
      int e = $urandom_range(0, 15), w = $urandom_range(0, 3), k = $urandom_range(0, 3);
      int op = $urandom_range(0, 4);
      logic [31:0] d = {tagPool[$urandom_range(0, 3)], 8'b0, 2'($urandom_range(0, 3))};
      case (op)
        0: tagWrite("R3 random", e, w, 0, d);
        1: tagWrite("R4 random", e, w, 1, d);
        2: tagRead("R5 random read", e, w, bit'($urandom_range(0, 1)));
        3: dataWrite(e, w, k, $urandom);
        default: dataRead("R7 random read", e, w, k);
      endcase
    end
    summary();
  end
endmodule